// File: doc/BRIEF.md
# Ethernet Single-Address Match Filter

This block watches the received byte stream of an Ethernet port and decides, frame by frame, whether one of the frame's two MAC address fields equals a single programmed 48-bit address. Software programs the address and its options through a pair of 32-bit words. The low word carries address bits 31:0. The high word carries bits 47:32 together with a field select and a per-byte don't-care mask. The filter is armed by writing the high word and disarmed by writing the low word, so a half-updated address can never produce a match.

The receive side presents one byte per cycle with a valid strobe, a start-of-frame flag on the first byte and an end-of-frame flag on the last byte. When the last byte of the selected address field has been accepted, the block raises its match output for one cycle if the filter was armed and every byte not marked don't-care agreed. The configuration a frame is judged against is captured when that frame starts, so register traffic during reception only affects later frames.

Top module: `mac_addr_filter`

## Requirements
- R1: After reset the filter is disarmed, both register words read as zero, and no frame produces a match, even one whose address bytes are all zero.
- R2: Writing the low word (select 0) stores address bits 31:0, which read back unchanged, and disarms the filter so that a matching frame produces no match.
- R3: Writing the high word (select 1) stores address bits 47:32 from data bits 15:0, the field select from bit 16 and the mask from bits 29:24, and arms the filter; data bits 31:30 and 23:17 are not stored and read back as zero.
- R4: With the field select at 0 the destination address, frame bytes 0 to 5, is compared; frame byte 0 compares against address bits 7:0 and frame byte 5 against bits 47:40.
- R5: With the field select at 1 the source address, frame bytes 6 to 11, is compared in the same byte order, and the destination bytes have no effect.
- R6: Mask bit 24+k set makes address byte k a don't-care; a cleared mask bit requires that byte to be equal.
- R7: The match output is high for exactly one cycle, in the cycle after the last byte of the selected field is accepted, and only when the filter was armed and all compared bytes agreed.
- R8: A frame whose end-of-frame flag arrives before the selected field is complete produces no match.
- R9: A register write during a frame does not change the result of that frame; it applies from the next start-of-frame.
- R10: A start-of-frame in the middle of a frame abandons the old frame and begins a fresh comparison from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_top | input | 1 | Word select for write: 0 low word, 1 high word |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_top | input | 1 | Word select for read: 0 low word, 1 high word |
| reg_rd_data | output | 32 | Register read data, combinational |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Received byte |
| match_o | output | 1 | One-cycle pulse when the selected field matches |

## Verification
A wrong byte counter or field base shows as a match pulse that is missing, extra, or one or more cycles off the expected slot, and it is visible on the very frame after the fault. A stuck mismatch flag or a configuration snapshot taken at the wrong time shows up as a frame whose verdict disagrees with the configuration present at its start, which the mid-frame write cases expose within two frames. Register storage faults show immediately on read-back of the two words.

// File: rtl/macflt_pkg.sv
// Package: shared constants and the configuration record of the
// single-address match filter. Assumes 8-bit receive lanes and a
// 48-bit address split over two 32-bit register words.
package macflt_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int WORD_W     = 32;
    localparam int HI_W       = ADDR_W - WORD_W;
    localparam int SRC_BIT    = 16;
    localparam int MASK_LSB   = 24;
    localparam int POS_W      = $clog2(ADDR_BYTES);
    localparam int CNT_MAX    = 2 * ADDR_BYTES;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic                  active;
        logic                  src_sel;
        logic [ADDR_BYTES-1:0] byte_mask;
        logic [ADDR_W-1:0]     addr;
    } filt_cfg_t;

endpackage

// File: rtl/macflt_regs.sv
// Module: register pair of the match filter. Low word holds address
// bits 31:0 and disarms on write; high word holds the upper address
// bits, field select and byte mask and arms on write. Unused high-word
// bits are not stored and read as zero. Read path is combinational.
module macflt_regs
    import macflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_top,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_top,
    output logic [WORD_W-1:0] rd_data,
    output filt_cfg_t         cfg
);

    logic [ADDR_W-1:0]     addr_q;
    logic [ADDR_BYTES-1:0] mask_q;
    logic                  src_q;
    logic                  act_q;

    // Store written fields and sequence the arm/disarm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            src_q  <= 1'b0;
            act_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_top) begin
                addr_q[ADDR_W-1:WORD_W] <= wr_data[HI_W-1:0];
                src_q                   <= wr_data[SRC_BIT];
                mask_q                  <= wr_data[MASK_LSB +: ADDR_BYTES];
                act_q                   <= 1'b1;
            end else begin
                addr_q[WORD_W-1:0] <= wr_data;
                act_q              <= 1'b0;
            end
        end
    end

    // Assemble the selected word for read-back; reserved bits stay zero.
    always_comb begin
        rd_data = '0;
        if (rd_top) begin
            rd_data[HI_W-1:0]                = addr_q[ADDR_W-1:WORD_W];
            rd_data[SRC_BIT]                 = src_q;
            rd_data[MASK_LSB +: ADDR_BYTES]  = mask_q;
        end else begin
            rd_data = addr_q[WORD_W-1:0];
        end
    end

    // Present the live configuration to the frame logic.
    always_comb begin
        cfg.active    = act_q;
        cfg.src_sel   = src_q;
        cfg.byte_mask = mask_q;
        cfg.addr      = addr_q;
    end

endmodule

// File: rtl/macflt_byte_cmp.sv
// Module: per-lane byte comparator. Each address byte has its own
// equality lane, forced true when masked; the lane for the current
// field position is selected. Assumes pos < ADDR_BYTES when used.
module macflt_byte_cmp
    import macflt_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ADDR_BYTES-1:0] byte_mask,
    input  logic [BYTE_W-1:0]     rx_data,
    input  logic [POS_W-1:0]      pos,
    output logic                  byte_ok
);

    logic [ADDR_BYTES-1:0] lane_ok;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        // One equality lane per address byte, overridden by its mask bit.
        assign lane_ok[g] = byte_mask[g] | (rx_data == addr[g*BYTE_W +: BYTE_W]);
    end

    // Pick the lane for the byte currently on the bus.
    always_comb begin
        byte_ok = 1'b0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (pos == POS_W'(i)) byte_ok = lane_ok[i];
        end
    end

endmodule

// File: rtl/macflt_frame_track.sv
// Module: frame tracker. Counts accepted bytes from start-of-frame,
// snapshots the configuration at start-of-frame, locates the selected
// address field, accumulates mismatches and issues the match pulse.
// Assumes one byte per cycle at most; bytes outside a frame are dropped.
module macflt_frame_track
    import macflt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  filt_cfg_t        live_cfg,
    input  logic             byte_ok,
    output filt_cfg_t        eff_cfg,
    output logic [POS_W-1:0] pos,
    output logic             match_o
);

    filt_cfg_t        frame_cfg;
    logic             in_frame;
    logic [CNT_W-1:0] cnt;
    logic             miss;

    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] base;
    logic             accepting;
    logic             in_field;
    logic             last_field;
    logic             miss_eff;

    // Decode the position of the current byte against the active field.
    always_comb begin
        eff_cfg    = rx_sof ? live_cfg : frame_cfg;
        idx        = rx_sof ? '0 : cnt;
        miss_eff   = rx_sof ? 1'b0 : miss;
        accepting  = rx_valid && (rx_sof || in_frame);
        base       = eff_cfg.src_sel ? CNT_W'(ADDR_BYTES) : '0;
        in_field   = accepting && (idx >= base) && (idx < base + CNT_W'(ADDR_BYTES));
        pos        = POS_W'(idx - base);
        last_field = in_field && (pos == POS_W'(ADDR_BYTES - 1));
    end

    // Advance frame state and register the match verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cfg <= '0;
            in_frame  <= 1'b0;
            cnt       <= '0;
            miss      <= 1'b0;
            match_o   <= 1'b0;
        end else begin
            match_o <= last_field && eff_cfg.active && !miss_eff && byte_ok;
            if (accepting) begin
                frame_cfg <= eff_cfg;
                cnt       <= (idx == CNT_W'(CNT_MAX)) ? idx : idx + 1'b1;
                miss      <= miss_eff | (in_field & ~byte_ok);
                in_frame  <= ~rx_eof;
            end
        end
    end

endmodule

// File: rtl/mac_addr_filter.sv
// Module: top of the single-address match filter. Joins the register
// pair, the frame tracker and the byte comparator. Assumes a single
// clock domain for register access and receive stream.
module mac_addr_filter
    import macflt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_wr_top,
    input  logic [31:0] reg_wr_data,
    input  logic        reg_rd_top,
    output logic [31:0] reg_rd_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    output logic        match_o
);

    filt_cfg_t        live_cfg;
    filt_cfg_t        eff_cfg;
    logic [POS_W-1:0] pos;
    logic             byte_ok;
    logic             live_active;

    assign live_active = live_cfg.active;

    macflt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_top  (reg_wr_top),
        .wr_data (reg_wr_data),
        .rd_top  (reg_rd_top),
        .rd_data (reg_rd_data),
        .cfg     (live_cfg)
    );

    macflt_frame_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .live_cfg (live_cfg),
        .byte_ok  (byte_ok),
        .eff_cfg  (eff_cfg),
        .pos      (pos),
        .match_o  (match_o)
    );

    macflt_byte_cmp u_cmp (
        .addr      (eff_cfg.addr),
        .byte_mask (eff_cfg.byte_mask),
        .rx_data   (rx_data),
        .pos       (pos),
        .byte_ok   (byte_ok)
    );

endmodule

// File: rtl/mac_addr_filter_checker.sv
// Module: protocol checker for the match filter, bound into the top.
// Observes ports and the live arm flag; drives nothing.
module mac_addr_filter_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        reg_wr_top,
    input logic        reg_rd_top,
    input logic [31:0] reg_rd_data,
    input logic        rx_valid,
    input logic        match_o,
    input logic        live_active
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!match_o && !live_active));

    p_low_write_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_top) |=> !live_active);

    p_high_write_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_top) |=> live_active);

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_top |-> (reg_rd_data[31:30] == 2'b00 && reg_rd_data[23:17] == 7'd0));

    p_match_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(rx_valid));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

endmodule

bind mac_addr_filter mac_addr_filter_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_top  (reg_wr_top),
    .reg_rd_top  (reg_rd_top),
    .reg_rd_data (reg_rd_data),
    .rx_valid    (rx_valid),
    .match_o     (match_o),
    .live_active (live_active)
);

// File: tb/mac_addr_filter_bench.sv
// Scoreboard bench: the frame driver predicts each match pulse and its
// cycle into a queue; a monitor pops and compares as pulses appear.
module mac_addr_filter_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_top = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_top = 1'b0;
    logic [31:0] reg_rd_data;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        match_o;

    mac_addr_filter u_mac_addr_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_top  (reg_wr_top),
        .reg_wr_data (reg_wr_data),
        .reg_rd_top  (reg_rd_top),
        .reg_rd_data (reg_rd_data),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .rx_data     (rx_data),
        .match_o     (match_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int unexp = 0;
    int exp_q[$];
    string req_q[$];
    logic [7:0] fbuf [16];

    // Model of the programmed state, kept from the requirements.
    logic [47:0] m_addr = '0;
    logic [5:0]  m_mask = '0;
    logic        m_src = 1'b0;
    logic        m_act = 1'b0;

    localparam logic [47:0] A = 48'h665544332211;
    localparam logic [47:0] B = 48'h0A0B0C0D0E0F;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every pulse must match the next predicted cycle (R7).
    always @(negedge clk) begin
        if (rst_n && match_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                unexp++;
                $display("FAIL R7 unexpected match pulse: actual cycle %0d, expected none", cyc);
            end else begin
                if (exp_q[0] != cyc) begin
                    fails++;
                    $display("FAIL %s match cycle: actual %0d, expected %0d", req_q[0], cyc, exp_q[0]);
                end
                void'(exp_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    task automatic model_write(input logic top, input logic [31:0] d);
        if (top) begin
            m_addr[47:32] = d[15:0];
            m_src = d[16];
            m_mask = d[29:24];
            m_act = 1'b1;
        end else begin
            m_addr[31:0] = d;
            m_act = 1'b0;
        end
    endtask

    task automatic write_reg(input logic top, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_top = top;
        reg_wr_data = d;
        model_write(top, d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic check_rd(input logic top, input logic [31:0] expv, input string req);
        @(negedge clk);
        reg_rd_top = top;
        #1;
        checks++;
        if (reg_rd_data !== expv) begin
            fails++;
            $display("FAIL %s read word %0d: actual %h, expected %h", req, top, reg_rd_data, expv);
        end
    endtask

    task automatic fill(input logic [47:0] dst, input logic [47:0] src);
        for (int i = 0; i < 16; i++) fbuf[i] = 8'hC0 + 8'(i);
        for (int k = 0; k < 6; k++) begin
            fbuf[k]     = dst[k*8 +: 8];
            fbuf[6 + k] = src[k*8 +: 8];
        end
    endtask

    // Driver: predict the verdict, push it, send bytes, then confirm.
    task automatic send_frame(input int len, input logic with_eof, input int wr_at,
                              input logic wr_top, input logic [31:0] wd, input string req);
        int base;
        logic hit;
        int unexp0;
        base = m_src ? 6 : 0;
        hit = m_act && (len >= base + 6);
        for (int k = 0; k < 6; k++)
            if (!m_mask[k] && (base + k < len) && fbuf[base + k] != m_addr[k*8 +: 8]) hit = 1'b0;
        unexp0 = unexp;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = with_eof && (i == len - 1);
            rx_data = fbuf[i];
            reg_wr_en = (i == wr_at);
            reg_wr_top = wr_top;
            reg_wr_data = wd;
            if (i == wr_at) model_write(wr_top, wd);
            if (hit && i == base + 5) begin
                exp_q.push_back(cyc + 1);
                req_q.push_back(req);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof = 1'b0;
        rx_eof = 1'b0;
        reg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || unexp != unexp0) begin
            fails++;
            $display("FAIL %s frame verdict: actual pending=%0d extra=%0d, expected match=%0d",
                     req, exp_q.size(), unexp - unexp0, hit);
            exp_q.delete();
            req_q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and disarmed filter
        check_rd(1'b0, 32'h0, "R1");
        check_rd(1'b1, 32'h0, "R1");
        for (int i = 0; i < 16; i++) fbuf[i] = 8'h00;
        send_frame(12, 1'b1, -1, 1'b0, 32'h0, "R1");

        // R2 / R3: program and read back
        write_reg(1'b0, 32'h44332211);
        write_reg(1'b1, 32'h00006655);
        check_rd(1'b0, 32'h44332211, "R2");
        check_rd(1'b1, 32'h00006655, "R3");

        // R4: destination compare and byte order
        fill(A, B);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R4");
        fill(A, B); fbuf[5] = 8'h67;
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R4");
        fill(48'h112233445566, B);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R4");

        // R5: source field select
        write_reg(1'b1, 32'h00016655);
        fill(A, B);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R5");
        fill(B, A);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R5");

        // R3: reserved bits dropped; R6: all bytes don't-care
        write_reg(1'b1, 32'hFFFF6655);
        check_rd(1'b1, 32'h3F016655, "R3");
        fill(B, B);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R6");

        // R6: single masked byte 2 (bit 26)
        write_reg(1'b1, 32'h04006655);
        fill(A, B); fbuf[2] = 8'h99;
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R6");
        fill(A, B); fbuf[3] = 8'h99;
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R6");

        // R2: low-word write disarms; R3: high-word write re-arms
        write_reg(1'b0, 32'h44332211);
        fill(A, B);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R2");
        write_reg(1'b1, 32'h00006655);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R3");

        // R8: frame ends before field completes
        fill(A, B);
        send_frame(5, 1'b1, -1, 1'b0, 32'h0, "R8");
        send_frame(6, 1'b1, -1, 1'b0, 32'h0, "R8");

        // R9: writes inside a frame apply from the next frame
        fill(A, B);
        send_frame(14, 1'b1, 2, 1'b0, 32'h44332211, "R9");
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R9");
        send_frame(14, 1'b1, 3, 1'b1, 32'h00006655, "R9");
        send_frame(14, 1'b1, 0, 1'b0, 32'h44332211, "R9");
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R9");
        write_reg(1'b1, 32'h00006655);

        // R10: restart by a new start-of-frame mid-frame
        fill(B, B);
        send_frame(3, 1'b0, -1, 1'b0, 32'h0, "R10");
        fill(A, B);
        send_frame(14, 1'b1, -1, 1'b0, 32'h0, "R10");

        finish_run();
    end

endmodule